// File: doc/BRIEF.md
# Core Memory-Access Sequencer

This block is the control state machine of a small in-order core. The core has one instruction port and one data port, and only one access is in flight at a time. The sequencer runs each instruction through the same steps. It asks a translation unit for the fetch address and sends the fetch. If the fetched word is a load or store, it translates the data address and then sends the data access. The instruction retires when the last response comes back. Decode, execution, translation internals and caches sit outside the block. Translation is modelled as a level request answered by a one-cycle done strobe that carries a fault flag and the physical address.

Each port uses a valid/ready handshake, sampled in the cycle the request is shown. A refused request is held until the port pulses its retry strobe, and is then shown again. An accepted request leaves the sequencer waiting for a response. A response may come back negatively acknowledged, and in that case the request is sent again in the same cycle. Responses are sampled on the core clock edge.

Software-visible control is limited to three inputs: an activate input, a suspend input, and a drain level that parks the core at an instruction boundary.

Top module: `mem_seq_fsm`

## Requirements
- R1: A request refused on either port (valid high, ready low) puts the sequencer in that port's retry state. It shows no request on that port until the retry strobe arrives. In the strobe cycle it shows the same address again.
- R2: A request accepted on either port puts the sequencer in that port's wait state. No new request appears on that port until a response arrives.
- R3: A negatively acknowledged response makes the sequencer show the same request again in that same cycle. If that re-send is refused, the R1 rules apply.
- R4: A retry strobe on a port that is not in its retry state sets `proto_err`. The flag stays set until reset. The strobe does not change the control state.
- R5: While `drain_req` is high and the sequencer is idle or between instructions, `drained` is high and no translation or memory request is shown. If an access is in flight when `drain_req` rises, `drained` rises after that access finishes.
- R6: If a fetch response (not NACKed) arrives while `drain_req` is high, the fetched word is discarded. There is no retire and `pc` is unchanged, and the same `pc` is fetched again once `drain_req` falls.
- R7: A faulting fetch translation issues no instruction request. In the next cycle `fault` pulses, `retire` stays low and `pc` equals `HANDLER_PC`.
- R8: A fetched word with `i_rsp_mem` set starts a data translation (`xlat_is_data`=1, vaddr = `i_rsp_daddr`). It then sends a data request at the translated address, with `d_req_write` = `i_rsp_write`. `retire` pulses and `pc` advances by 4 only after the good data response.
- R9: A faulting data translation issues no data request. In the next cycle `retire` and `fault` both pulse and `pc` equals `HANDLER_PC`.
- R10: `suspend` has no effect when idle. Between instructions it moves the sequencer to idle. During an access it takes effect after that instruction completes, so no further fetch starts.
- R11: Reset leaves the sequencer idle, with `pc` = `RESET_PC` and every request, pulse and error output low. `activate` starts fetching from idle.
- R12: A fetched word with `i_rsp_mem` clear retires in the next cycle and advances `pc` by 4. Every fetch response that is kept produces exactly one retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate | input | 1 | Start fetching when idle |
| suspend | input | 1 | Stop after the current instruction |
| drain_req | input | 1 | Level request to park at an instruction boundary |
| drained | output | 1 | Parked while drain is requested |
| xlat_req | output | 1 | Translation request (level) |
| xlat_is_data | output | 1 | Translation is for a data access |
| xlat_vaddr | output | AW | Virtual address to translate |
| xlat_done | input | 1 | Translation result strobe |
| xlat_fault | input | 1 | Translation faulted |
| xlat_paddr | input | AW | Translated address |
| i_req_valid | output | 1 | Instruction request shown |
| i_req_ready | input | 1 | Instruction port accepts this cycle |
| i_req_addr | output | AW | Instruction request address |
| i_retry | input | 1 | Instruction port retry strobe |
| i_rsp_valid | input | 1 | Instruction response strobe |
| i_rsp_nack | input | 1 | Response is a negative acknowledge |
| i_rsp_mem | input | 1 | Fetched word is a load or store |
| i_rsp_write | input | 1 | Fetched memory op is a store |
| i_rsp_daddr | input | AW | Data virtual address of fetched op |
| d_req_valid | output | 1 | Data request shown |
| d_req_ready | input | 1 | Data port accepts this cycle |
| d_req_addr | output | AW | Data request address |
| d_req_write | output | 1 | Data request is a store |
| d_retry | input | 1 | Data port retry strobe |
| d_rsp_valid | input | 1 | Data response strobe |
| d_rsp_nack | input | 1 | Data response is a negative acknowledge |
| retire | output | 1 | Instruction completed (pulse) |
| fault | output | 1 | Redirected to fault handler (pulse) |
| pc | output | AW | Current program counter |
| proto_err | output | 1 | Sticky retry protocol error |

## Verification
The hardest case to reach from the ports is a drain request that overlaps an access at a late step. Examples are a drain that lands on the very cycle a fetch word returns, or while a refused re-send of a NACK is parked in a retry state. The bench gets there by running a reactive port model that refuses, NACKs and delays responses at random. Meanwhile drain requests are raised and dropped at random through a sweep over every on/off combination of refusal, NACK, fault and drain stimulus. The bench's own program-counter model follows every discard, fault and retire, and a final tally checks that each kept fetch retired exactly once.

// File: rtl/mem_seq_fsm.sv
module mem_seq_fsm #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = 'h1000,
  parameter logic [AW-1:0] HANDLER_PC = 'h100,
  parameter int ISTEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          activate,
  input  logic          suspend,
  input  logic          drain_req,
  output logic          drained,
  output logic          xlat_req,
  output logic          xlat_is_data,
  output logic [AW-1:0] xlat_vaddr,
  input  logic          xlat_done,
  input  logic          xlat_fault,
  input  logic [AW-1:0] xlat_paddr,
  output logic          i_req_valid,
  input  logic          i_req_ready,
  output logic [AW-1:0] i_req_addr,
  input  logic          i_retry,
  input  logic          i_rsp_valid,
  input  logic          i_rsp_nack,
  input  logic          i_rsp_mem,
  input  logic          i_rsp_write,
  input  logic [AW-1:0] i_rsp_daddr,
  output logic          d_req_valid,
  input  logic          d_req_ready,
  output logic [AW-1:0] d_req_addr,
  output logic          d_req_write,
  input  logic          d_retry,
  input  logic          d_rsp_valid,
  input  logic          d_rsp_nack,
  output logic          retire,
  output logic          fault,
  output logic [AW-1:0] pc,
  output logic          proto_err
);

  typedef enum logic [2:0] {
    S_IDLE, S_RUN, S_XLAT, S_IRETRY, S_IWAIT, S_DRETRY, S_DWAIT
  } st_t;

  localparam logic [AW-1:0] STEP = AW'(ISTEP);

  st_t           state;
  logic          xl_data;
  logic          mem_wr;
  logic [AW-1:0] daddr;
  logic [AW-1:0] paddr_q;
  logic          susp_pend;
  st_t           resume_st;
  logic          xl_ok;

  assign xl_ok        = (state == S_XLAT) && xlat_done && !xlat_fault;
  assign resume_st    = (susp_pend || suspend) ? S_IDLE : S_RUN;
  assign drained      = drain_req && (state == S_IDLE || state == S_RUN);
  assign xlat_req     = (state == S_XLAT);
  assign xlat_is_data = xl_data;
  assign xlat_vaddr   = xl_data ? daddr : pc;

  assign i_req_valid = (xl_ok && !xl_data)
                    || (state == S_IRETRY && i_retry)
                    || (state == S_IWAIT && i_rsp_valid && i_rsp_nack);
  assign d_req_valid = (xl_ok && xl_data)
                    || (state == S_DRETRY && d_retry)
                    || (state == S_DWAIT && d_rsp_valid && d_rsp_nack);
  assign i_req_addr  = (state == S_XLAT) ? xlat_paddr : paddr_q;
  assign d_req_addr  = (state == S_XLAT) ? xlat_paddr : paddr_q;
  assign d_req_write = mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      xl_data   <= 1'b0;
      mem_wr    <= 1'b0;
      daddr     <= '0;
      paddr_q   <= '0;
      susp_pend <= 1'b0;
      pc        <= RESET_PC;
      retire    <= 1'b0;
      fault     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      retire <= 1'b0;
      fault  <= 1'b0;
      if ((i_retry && state != S_IRETRY) || (d_retry && state != S_DRETRY))
        proto_err <= 1'b1;
      if (suspend && state != S_IDLE && state != S_RUN)
        susp_pend <= 1'b1;
      case (state)
        S_IDLE: if (activate) state <= S_RUN;
        S_RUN: begin
          if (suspend) state <= S_IDLE;
          else if (!drain_req) begin
            state   <= S_XLAT;
            xl_data <= 1'b0;
          end
        end
        S_XLAT: if (xlat_done) begin
          if (xlat_fault) begin
            fault     <= 1'b1;
            retire    <= xl_data;
            pc        <= HANDLER_PC;
            state     <= resume_st;
            susp_pend <= 1'b0;
          end else begin
            paddr_q <= xlat_paddr;
            if (xl_data) state <= d_req_ready ? S_DWAIT : S_DRETRY;
            else         state <= i_req_ready ? S_IWAIT : S_IRETRY;
          end
        end
        S_IRETRY: if (i_retry && i_req_ready) state <= S_IWAIT;
        S_IWAIT: if (i_rsp_valid) begin
          if (i_rsp_nack) begin
            if (!i_req_ready) state <= S_IRETRY;
          end else if (drain_req) begin
            state     <= resume_st;
            susp_pend <= 1'b0;
          end else if (i_rsp_mem) begin
            daddr   <= i_rsp_daddr;
            mem_wr  <= i_rsp_write;
            xl_data <= 1'b1;
            state   <= S_XLAT;
          end else begin
            retire    <= 1'b1;
            pc        <= pc + STEP;
            state     <= resume_st;
            susp_pend <= 1'b0;
          end
        end
        S_DRETRY: if (d_retry && d_req_ready) state <= S_DWAIT;
        S_DWAIT: if (d_rsp_valid) begin
          if (d_rsp_nack) begin
            if (!d_req_ready) state <= S_DRETRY;
          end else begin
            retire    <= 1'b1;
            pc        <= pc + STEP;
            state     <= resume_st;
            susp_pend <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IREFUSE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req_valid && !i_req_ready) |=> (state == S_IRETRY && !i_req_valid) || i_retry); // R1
  AST_DREFUSE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid && !d_req_ready) |=> (state == S_DRETRY && !d_req_valid) || d_retry); // R1
  AST_IACCEPT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req_valid && i_req_ready) |=> state == S_IWAIT); // R2
  AST_DACCEPT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid && d_req_ready) |=> state == S_DWAIT); // R2
  AST_INACK_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IWAIT && i_rsp_valid && i_rsp_nack) |-> i_req_valid && i_req_addr == paddr_q); // R3
  AST_STRAY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (i_retry && state != S_IRETRY) |=> proto_err); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R4
  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !xlat_req && !i_req_valid && !d_req_valid); // R5
  AST_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && !xlat_is_data && xlat_done && xlat_fault) |=> fault && !retire && pc == HANDLER_PC); // R7
  AST_DATA_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && xlat_is_data && xlat_done && xlat_fault) |-> !d_req_valid); // R9
  AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_req_valid && d_req_valid)); // R2
  AST_IDLE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !activate) |=> state == S_IDLE); // R10

endmodule

// File: tb/sim_mem_seq_fsm.sv
`timescale 1ns/1ps
module sim_mem_seq_fsm;
  localparam logic [31:0] RST_PC = 32'h1000;
  localparam logic [31:0] HND_PC = 32'h100;
  localparam logic [31:0] OFF    = 32'h4000_0000;

  logic clk = 0, rst_n = 0, activate = 0, suspend = 0, drain_req = 0;
  logic drained, xlat_req, xlat_is_data, xlat_done = 0, xlat_fault = 0;
  logic [31:0] xlat_vaddr, xlat_paddr = 0, i_req_addr, d_req_addr, pc, i_rsp_daddr = 0;
  logic i_req_valid, i_req_ready = 0, i_retry = 0, i_rsp_valid = 0, i_rsp_nack = 0;
  logic i_rsp_mem = 0, i_rsp_write = 0;
  logic d_req_valid, d_req_ready = 0, d_req_write, d_retry = 0, d_rsp_valid = 0, d_rsp_nack = 0;
  logic retire, fault, proto_err;

  always #2 clk = ~clk;

  mem_seq_fsm u0 (.*);

  int checks = 0, errors = 0;
  bit env_on = 0, inj_i = 0, inj_d = 0;
  int p_ref = 0, p_nack = 0, p_flt = 0, p_drain = 0;
  bit xl_busy, i_busy, i_rp, d_busy, d_rp, exp_r, exp_f, exp_dwr, nk;
  int xl_w, i_w, i_rw, d_w, d_rw, dw, fetch_kept, retires, done_cnt;
  logic [31:0] i_hold, d_hold, exp_pc, exp_daddr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic env_clear();
    xl_busy = 0; i_busy = 0; i_rp = 0; d_busy = 0; d_rp = 0;
    exp_r = 0; exp_f = 0; exp_pc = RST_PC; dw = 0;
  endtask

  always @(negedge clk) if (env_on) begin
    chk(retire == exp_r, "R12", "retire", 32'(retire), 32'(exp_r));
    chk(fault == exp_f, (exp_f && !exp_r) ? "R7" : "R9", "fault", 32'(fault), 32'(exp_f));
    chk(pc == exp_pc, exp_f ? "R7" : "R8", "pc", pc, exp_pc);
    if (retire || fault) done_cnt++;
    if (retire) retires++;
    exp_r = 0; exp_f = 0;
    xlat_done = 0; xlat_fault = 0; i_rsp_valid = 0; i_rsp_nack = 0; d_rsp_valid = 0; d_rsp_nack = 0;
    i_retry = inj_i; d_retry = inj_d;
    if (p_drain == 0) drain_req = 0;
    else if (!drain_req && ($urandom % 100) < p_drain) drain_req = 1;
    else if (drain_req && drained && ($urandom % 100) < 30) drain_req = 0;
    if (xlat_req) begin
      if (!xl_busy) begin
        xl_busy = 1; xl_w = $urandom % 3;
        if (xlat_is_data) chk(xlat_vaddr == exp_daddr, "R8", "data vaddr", xlat_vaddr, exp_daddr);
        else              chk(xlat_vaddr == exp_pc, "R6", "fetch vaddr", xlat_vaddr, exp_pc);
      end
      if (xl_w == 0) begin
        xl_busy = 0; xlat_done = 1; xlat_paddr = xlat_vaddr + OFF;
        xlat_fault = ($urandom % 100) < p_flt;
        if (xlat_fault) begin exp_pc = HND_PC; exp_f = 1; exp_r = xlat_is_data; end
      end else xl_w--;
    end
    if (i_busy) begin
      if (i_w == 0) begin
        i_rsp_valid = 1; nk = ($urandom % 100) < p_nack; i_rsp_nack = nk;
        if (!nk) begin
          i_busy = 0; i_rsp_mem = $urandom % 2; i_rsp_write = $urandom % 2;
          i_rsp_daddr = $urandom & 32'h0000_FFFC;
          if (!drain_req) begin
            fetch_kept++;
            if (i_rsp_mem) begin exp_daddr = i_rsp_daddr; exp_dwr = i_rsp_write; end
            else begin exp_pc = exp_pc + 4; exp_r = 1; end
          end
        end
      end else i_w--;
    end
    if (d_busy) begin
      if (d_w == 0) begin
        d_rsp_valid = 1; nk = ($urandom % 100) < p_nack; d_rsp_nack = nk;
        if (!nk) begin d_busy = 0; exp_pc = exp_pc + 4; exp_r = 1; end
      end else d_w--;
    end
    if (i_rp) begin if (i_rw == 0) i_retry = 1; else i_rw--; end
    if (d_rp) begin if (d_rw == 0) d_retry = 1; else d_rw--; end
    i_req_ready = ($urandom % 100) >= p_ref;
    d_req_ready = ($urandom % 100) >= p_ref;
    #1;
    if (i_req_valid) begin
      if (i_rp) chk(i_retry && i_req_addr == i_hold, "R1", "retry resend addr", i_req_addr, i_hold);
      else if (i_busy) begin
        chk(i_rsp_valid && i_rsp_nack, "R2", "request while waiting", 32'(i_rsp_valid), 1);
        chk(i_req_addr == i_hold, "R3", "nack resend addr", i_req_addr, i_hold);
      end else chk(xlat_done && i_req_addr == exp_pc + OFF, "R11", "fetch addr", i_req_addr, exp_pc + OFF);
      i_hold = i_req_addr; i_rp = 0;
      if (i_req_ready) begin i_busy = 1; i_w = $urandom % 3; end
      else begin i_busy = 0; i_rp = 1; i_rw = $urandom % 3; end
    end else begin
      if (i_retry && !inj_i) chk(0, "R1", "strobe without resend", 0, 1);
      if (i_rsp_valid && i_rsp_nack) chk(0, "R3", "nack without resend", 0, 1);
    end
    if (d_req_valid) begin
      chk(d_req_write == exp_dwr, "R8", "write flag", 32'(d_req_write), 32'(exp_dwr));
      if (d_rp) chk(d_retry && d_req_addr == d_hold, "R1", "data retry resend", d_req_addr, d_hold);
      else if (d_busy) begin
        chk(d_rsp_valid && d_rsp_nack, "R2", "data request while waiting", 32'(d_rsp_valid), 1);
        chk(d_req_addr == d_hold, "R3", "data nack resend addr", d_req_addr, d_hold);
      end else chk(xlat_done && d_req_addr == exp_daddr + OFF, "R8", "data addr", d_req_addr, exp_daddr + OFF);
      d_hold = d_req_addr; d_rp = 0;
      if (d_req_ready) begin d_busy = 1; d_w = $urandom % 3; end
      else begin d_busy = 0; d_rp = 1; d_rw = $urandom % 3; end
    end else begin
      if (d_retry && !inj_d) chk(0, "R1", "data strobe without resend", 0, 1);
      if (d_rsp_valid && d_rsp_nack) chk(0, "R3", "data nack without resend", 0, 1);
    end
    if (drained) chk(!xlat_req && !i_req_valid && !d_req_valid, "R5", "activity while drained", 32'(xlat_req), 0);
    if (drain_req && !drained) begin
      dw++;
      if (dw == 80) chk(0, "R5", "drain never completed", 0, 1);
    end else dw = 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    env_on = 0; rst_n = 0; cyc(2); env_clear(); rst_n = 1;
  endtask

  initial begin
    int quiet;
    env_clear();
    cyc(3);
    chk(pc == RST_PC, "R11", "reset pc", pc, RST_PC);
    chk(!xlat_req && !i_req_valid && !d_req_valid, "R11", "reset requests", 32'(xlat_req), 0);
    chk(!retire && !fault && !proto_err && !drained, "R11", "reset flags", 32'(proto_err), 0);
    rst_n = 1; env_on = 1;
    suspend = 1; cyc(1); suspend = 0; cyc(6);
    chk(!xlat_req && pc == RST_PC, "R10", "suspend while idle", 32'(xlat_req), 0);
    activate = 1; cyc(1); activate = 0; cyc(1);
    chk(xlat_req && !xlat_is_data, "R11", "activate starts fetch", 32'(xlat_req), 1);
    for (int m = 0; m < 16; m++) begin
      p_ref = m[0] ? 40 : 0; p_nack = m[1] ? 30 : 0;
      p_flt = m[2] ? 15 : 0; p_drain = m[3] ? 6 : 0;
      cyc(300);
    end
    p_drain = 0; cyc(3);
    done_cnt = 0; suspend = 1; cyc(1); suspend = 0;
    quiet = 0;
    for (int k = 0; k < 200 && quiet < 10; k++) begin
      cyc(1);
      if (xlat_req || i_req_valid || d_req_valid) quiet = 0; else quiet++;
    end
    chk(quiet >= 10, "R10", "suspend reached idle", 32'(quiet), 10);
    chk(done_cnt <= 1, "R10", "completions after suspend", 32'(done_cnt), 1);
    cyc(20);
    chk(!xlat_req && !i_req_valid && !d_req_valid, "R10", "no fetch after suspend", 32'(xlat_req), 0);
    chk(fetch_kept == retires, "R12", "kept fetches retired once", 32'(retires), 32'(fetch_kept));
    chk(retires > 100, "R12", "enough retires", 32'(retires), 101);
    inj_i = 1; cyc(1); inj_i = 0; cyc(1);
    chk(proto_err, "R4", "stray instruction retry", 32'(proto_err), 1);
    cyc(3);
    chk(proto_err && !xlat_req, "R4", "sticky and state unchanged", 32'(xlat_req), 0);
    do_reset(); cyc(1);
    chk(!proto_err && pc == RST_PC, "R11", "reset clears error", 32'(proto_err), 0);
    env_on = 1;
    inj_d = 1; cyc(1); inj_d = 0; cyc(1);
    chk(proto_err, "R4", "stray data retry", 32'(proto_err), 1);
    env_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule